// File: doc/BRIEF.md
# Relocatable Pin-Port and Machine-Timer Window

This block is a byte-addressed peripheral window that software can move anywhere in a 32-bit address space. It holds three resources. The first is a small general-purpose pin port with a per-pin direction bit and a data register. The second is a free-running 64-bit machine timer. The third is a 64-bit compare value. The block raises two interrupt pending bits: one for the timer and one for activity on input pins.

The window start comes from a base-address input, which a control register elsewhere drives. A base of zero turns the window off. Any non-zero base turns it on, with no alignment rule. The window spans 256 bytes, and matching wraps around the top of the address space. A write is a single-cycle pulse on `bus_we`. Read data is combinational from the address.

The pin-input interrupt is a two-state machine. The states are `PIN_QUIET` (nothing pending) and `PIN_PEND` (an input change is pending). It has two transitions. QUIET→PEND is taken on any change of an input-configured pin. PEND→QUIET is taken on a write to the data register, unless an input change occurs in that same cycle.

Top module: `mmio_gpio_timer`

## Requirements
- R1: The window matches (`win_sel`=1) when `win_base` is non-zero and `(bus_addr - win_base) mod 2^32` is below 256. With no match, `bus_rdata` is 0 and writes change nothing. A base of 0 never matches.
- R2: After reset, direction is all inputs, the stored pin outputs are 0, the timer is 0, the compare value is all ones, and `irq_pending` is 0.
- R3: Offset 0 is the direction register. Bit i set makes pin i an output, and `pin_oe` shows these bits. Bits 7:4 read as 0 whatever was written.
- R4: Offset 1 is the data register. Bits for output pins read the stored value. Bits for input pins read `pin_in` and ignore writes. `pin_out` carries the stored value on output pins and 0 on input pins.
- R5: Offsets 2..9 read the timer as little-endian bytes, with offset 2 the least significant. Each cycle with `tick`=1 adds one, with carry across all 64 bits. With `tick`=0 the timer holds.
- R6: A write to a timer byte replaces that byte. The timer does not increment in that cycle, even with `tick`=1.
- R7: Offsets 10..17 are the compare value as little-endian bytes, each writable alone. The compare value otherwise holds.
- R8: `irq_pending[7]` is 1 exactly while the timer is unsigned greater than or equal to the compare value.
- R9: A change on any input-configured pin moves the machine to `PIN_PEND` at the next clock edge. Changes on output-configured pins are ignored. `irq_pending[16]` is 1 in `PIN_PEND`.
- R10: A write to offset 1 returns the machine to `PIN_QUIET`. If an input change arrives in the same cycle, it stays in `PIN_PEND`. All `irq_pending` bits other than 7 and 16 are 0.
- R11: Offsets 18..255 read 0, and writes to them change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_base | input | 32 | Window start address; 0 disables |
| bus_addr | input | 32 | Byte address |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| win_sel | output | 1 | Address lies in the window |
| tick | input | 1 | Timer increment enable |
| pin_in | input | 4 | Sampled pin levels |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Pin output enables |
| irq_pending | output | 32 | Pending word: bit 7 timer, bit 16 pin input |

## Verification
Some rules are checked by the assertions on every clock:
- the timer counts up or holds according to `tick` and timer writes;
- the compare value and the direction bits change only when written;
- input bits of the data register never take write data;
- the pin machine enters and stays in `PIN_PEND` correctly;
- an unmatched or reserved address reads 0.

Other behaviour only the directed scenarios can show:
- wrap-around window matching;
- the little-endian byte order and carry across the 32-bit boundary;
- the exact cycle at which the timer interrupt rises against the compare value;
- the mixed read of input and output pins;
- the same-cycle race between a data write and an input change.

// File: rtl/mmio_win_pkg.sv
package mmio_win_pkg;

    // Offsets whose order is fixed by the register layout
    localparam int unsigned DIR_OFF  = 0;
    localparam int unsigned DATA_OFF = 1;
    localparam int unsigned TMR_OFF  = 2;

    // Pending-word bit positions
    localparam int unsigned TMR_IRQ_BIT = 7;
    localparam int unsigned PIN_IRQ_BIT = 16;

    typedef enum logic {
        PIN_QUIET = 1'b0,
        PIN_PEND  = 1'b1
    } pin_st_e;

endpackage

// File: rtl/win_decode.sv
module win_decode #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SPAN_LOG2 = 8
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [SPAN_LOG2-1:0] off
);

    logic [ADDR_W-1:0] delta;

    // Modular distance from the base; wrap-around is natural here
    assign delta = addr - base;
    assign off   = delta[SPAN_LOG2-1:0];
    assign hit   = (|base) && (delta[ADDR_W-1:SPAN_LOG2] == '0);

endmodule

// File: rtl/pin_port.sv
module pin_port
    import mmio_win_pkg::*;
#(
    parameter int unsigned PINS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_wr,
    input  logic            data_wr,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] dir,
    output logic [PINS-1:0] drive,
    output logic [7:0]      rd_dir,
    output logic [7:0]      rd_data,
    output logic            irq
);

    logic [PINS-1:0] out_q;
    logic [PINS-1:0] prev_q;
    logic            in_evt;
    pin_st_e         st_q;
    pin_st_e         st_d;

    // Register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir    <= '0;
            out_q  <= '0;
            prev_q <= '0;
        end else begin
            prev_q <= pin_in;
            if (dir_wr) begin
                dir <= wdata;
            end
            if (data_wr) begin
                out_q <= (out_q & ~dir) | (wdata & dir);
            end
        end
    end

    // Input-change detection on input-configured pins only
    assign in_evt = |((pin_in ^ prev_q) & ~dir);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PIN_QUIET;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_QUIET: st_d = in_evt ? PIN_PEND : PIN_QUIET;
            PIN_PEND:  st_d = (data_wr && !in_evt) ? PIN_QUIET : PIN_PEND;
            default:   st_d = PIN_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        irq     = (st_q == PIN_PEND);
        drive   = out_q & dir;
        rd_dir  = 8'(dir);
        rd_data = 8'((out_q & dir) | (pin_in & ~dir));
    end

    p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_wr |=> $stable(dir));

    p_in_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> ((out_q ^ $past(out_q)) & ~$past(dir)) == '0);

    p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(out_q));

    p_pend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_evt |=> irq);

    p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !data_wr) |=> irq);

    p_pend_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !in_evt) |=> !irq);

endmodule

// File: rtl/mach_timer.sv
module mach_timer #(
    parameter int unsigned BYTES    = 8,
    parameter int unsigned OFF_W    = 8,
    parameter int unsigned TMR_BASE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_data,
    output logic             rd_hit,
    output logic             irq
);

    localparam int unsigned W        = 8 * BYTES;
    localparam int unsigned CMP_BASE = TMR_BASE + BYTES;

    logic [W-1:0]     timer_q;
    logic [W-1:0]     timer_d;
    logic [W-1:0]     cmp_q;
    logic [W-1:0]     cmp_d;
    logic [BYTES-1:0] t_hit;
    logic [BYTES-1:0] c_hit;
    logic [BYTES-1:0] t_wr;
    logic [BYTES-1:0] c_wr;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign t_hit[b] = (off == OFF_W'(TMR_BASE + b));
        assign c_hit[b] = (off == OFF_W'(CMP_BASE + b));
        assign t_wr[b]  = wr && t_hit[b];
        assign c_wr[b]  = wr && c_hit[b];
    end

    always_comb begin
        timer_d = (tick && !(|t_wr)) ? timer_q + W'(1) : timer_q;
        cmp_d   = cmp_q;
        for (int b = 0; b < BYTES; b++) begin
            if (t_wr[b]) timer_d[8*b +: 8] = wdata;
            if (c_wr[b]) cmp_d[8*b +: 8]   = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            cmp_q   <= '1;
        end else begin
            timer_q <= timer_d;
            cmp_q   <= cmp_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (t_hit[b]) rd_data = timer_q[8*b +: 8];
            if (c_hit[b]) rd_data = cmp_q[8*b +: 8];
        end
        rd_hit = (|t_hit) || (|c_hit);
        irq    = (timer_q >= cmp_q);
    end

    p_tick_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(|t_wr)) |=> timer_q == $past(timer_q) + W'(1));

    p_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(|t_wr)) |=> $stable(timer_q));

    p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|c_wr) |=> $stable(cmp_q));

    p_one_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(t_wr | c_wr) <= 1);

endmodule

// File: rtl/mmio_gpio_timer.sv
module mmio_gpio_timer
    import mmio_win_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned SPAN_LOG2   = 8,
    parameter int unsigned PIN_COUNT   = 4,
    parameter int unsigned TIMER_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    win_base,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic                 win_sel,
    input  logic                 tick,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [31:0]          irq_pending
);

    localparam int unsigned RSVD_OFF = TMR_OFF + 2 * TIMER_BYTES;

    logic [SPAN_LOG2-1:0] off;
    logic                 hit_wr;
    logic                 dir_wr;
    logic                 data_wr;
    logic [7:0]           dir_rd;
    logic [7:0]           data_rd;
    logic [7:0]           tmr_rd;
    logic                 tmr_hit;
    logic                 tmr_irq;
    logic                 pin_irq;

    win_decode #(
        .ADDR_W   (ADDR_W),
        .SPAN_LOG2(SPAN_LOG2)
    ) u_dec (
        .base(win_base),
        .addr(bus_addr),
        .hit (win_sel),
        .off (off)
    );

    assign hit_wr  = win_sel && bus_we;
    assign dir_wr  = hit_wr && (off == SPAN_LOG2'(DIR_OFF));
    assign data_wr = hit_wr && (off == SPAN_LOG2'(DATA_OFF));

    pin_port #(
        .PINS(PIN_COUNT)
    ) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_wr (dir_wr),
        .data_wr(data_wr),
        .wdata  (bus_wdata[PIN_COUNT-1:0]),
        .pin_in (pin_in),
        .dir    (pin_oe),
        .drive  (pin_out),
        .rd_dir (dir_rd),
        .rd_data(data_rd),
        .irq    (pin_irq)
    );

    mach_timer #(
        .BYTES   (TIMER_BYTES),
        .OFF_W   (SPAN_LOG2),
        .TMR_BASE(TMR_OFF)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr     (hit_wr),
        .off    (off),
        .wdata  (bus_wdata),
        .rd_data(tmr_rd),
        .rd_hit (tmr_hit),
        .irq    (tmr_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (win_sel) begin
            if (off == SPAN_LOG2'(DIR_OFF))       bus_rdata = dir_rd;
            else if (off == SPAN_LOG2'(DATA_OFF)) bus_rdata = data_rd;
            else if (tmr_hit)                     bus_rdata = tmr_rd;
        end
    end

    always_comb begin
        irq_pending              = '0;
        irq_pending[TMR_IRQ_BIT] = tmr_irq;
        irq_pending[PIN_IRQ_BIT] = pin_irq;
    end

    p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !win_sel |-> bus_rdata == 8'h00);

    p_base_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base == '0) |-> !win_sel);

    p_rsvd_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel && (32'(off) >= RSVD_OFF)) |-> bus_rdata == 8'h00);

    p_dir_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel && off == SPAN_LOG2'(DIR_OFF)) |-> bus_rdata[7:PIN_COUNT] == '0);

endmodule

// File: tb/mmio_gpio_timer_test.sv
module mmio_gpio_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] win_base = 32'h0;
    logic [31:0] bus_addr = 32'h0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        win_sel;
    logic        tick = 1'b0;
    logic [3:0]  pin_in = 4'h0;
    logic [3:0]  pin_out;
    logic [3:0]  pin_oe;
    logic [31:0] irq_pending;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [31:0] B = 32'h0000_1003;

    mmio_gpio_timer uut (
        .clk(clk), .rst_n(rst_n), .win_base(win_base), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .win_sel(win_sel), .tick(tick), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_pending(irq_pending)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic rd64(input logic [31:0] a, output logic [63:0] v);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(a + i, d);
            v[8*i +: 8] = d;
        end
    endtask

    task automatic wr64(input logic [31:0] a, input logic [63:0] v);
        for (int i = 7; i >= 0; i--) wr(a + i, v[8*i +: 8]);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        logic [7:0]  d;
        win_base = B;
        check("R2 oe", 64'(pin_oe), 0);
        check("R2 out", 64'(pin_out), 0);
        check("R2 irq", 64'(irq_pending), 0);
        rd64(B + 2, v);  check("R2 timer", v, 0);
        rd64(B + 10, v); check("R2 cmp", v, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(B + 1, d);    check("R2 data", 64'(d), 0);
    endtask

    task automatic t_window();
        logic [7:0] d;
        win_base = 32'h0;
        wr(32'h0, 8'h0F);
        wr(B, 8'h0F);
        check("R1 base0 sel", 64'(win_sel), 0);
        check("R1 base0 write ignored", 64'(pin_oe), 0);
        rd(32'h0, d); check("R1 base0 read", 64'(d), 0);
        win_base = 32'hFFFF_FFF0;
        rd(32'h0000_0000, d); check("R1 wrap hit cmp byte6", 64'(d), 8'hFF);
        rd(32'hFFFF_FFEF, d); check("R1 below base", 64'({win_sel, d}), 0);
        rd(32'h0000_00EF, d); check("R1 last byte sel", 64'(win_sel), 1);
        rd(32'h0000_00F0, d); check("R1 past end", 64'({win_sel, d}), 0);
        win_base = B;
    endtask

    task automatic t_dir();
        logic [7:0] d;
        wr(B, 8'hA5);
        rd(B, d); check("R3 dir read", 64'(d), 8'h05);
        check("R3 oe", 64'(pin_oe), 4'h5);
    endtask

    task automatic t_pins();
        logic [7:0] d;
        wr(B + 1, 8'hFF);
        check("R4 out", 64'(pin_out), 4'h5);
        @(negedge clk) pin_in = 4'hA;
        @(posedge clk); #1;
        check("R9 input change pends", 64'(irq_pending), 32'h0001_0000);
        rd(B + 1, d); check("R4 mixed read", 64'(d), 8'h0F);
        wr(B + 1, 8'h00);
        check("R10 write clears", 64'(irq_pending[16]), 0);
        check("R4 out cleared", 64'(pin_out), 0);
        rd(B + 1, d); check("R4 read inputs", 64'(d), 8'h0A);
        @(negedge clk) pin_in = 4'hB;
        repeat (2) @(posedge clk); #1;
        check("R9 output pin ignored", 64'(irq_pending[16]), 0);
        @(negedge clk);
        pin_in = 4'h9; bus_addr = B + 1; bus_wdata = 8'h04; bus_we = 1'b1;
        @(posedge clk); #1 bus_we = 1'b0;
        check("R10 race keeps pend", 64'(irq_pending[16]), 1);
        check("R4 out after race", 64'(pin_out), 4'h4);
        @(negedge clk) pin_in = 4'h0;
        wr(B + 1, 8'hFF);
        rd(B + 1, d); check("R4 input bits ignore writes", 64'(d), 8'h05);
        check("R10 cleared again", 64'(irq_pending), 0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr(B + 18, 8'h55);
        wr(B + 255, 8'h55);
        rd(B + 18, d);  check("R11 read 18", 64'(d), 0);
        rd(B + 255, d); check("R11 read 255", 64'(d), 0);
        rd(B, d);       check("R11 dir untouched", 64'(d), 8'h05);
        rd(B + 1, d);   check("R11 data untouched", 64'(d), 8'h05);
    endtask

    task automatic t_timer();
        logic [63:0] v;
        wr64(B + 2, 64'h0000_0000_FFFF_FFFF);
        ticks(2);
        rd64(B + 2, v); check("R5 carry", v, 64'h0000_0001_0000_0001);
        rd64(B + 2, v); check("R5 hold", v, 64'h0000_0001_0000_0001);
        wr64(B + 2, 64'h0);
        @(negedge clk);
        tick = 1'b1; bus_addr = B + 2; bus_wdata = 8'h20; bus_we = 1'b1;
        @(posedge clk); #1 tick = 1'b0; bus_we = 1'b0;
        rd64(B + 2, v); check("R6 write beats tick", v, 64'h20);
        wr64(B + 10, 64'h10);
        rd64(B + 10, v); check("R7 cmp bytes", v, 64'h10);
        check("R8 above cmp", 64'(irq_pending[7]), 1);
        wr64(B + 2, 64'h0E);
        check("R8 below cmp", 64'(irq_pending[7]), 0);
        ticks(1);
        check("R8 one under", 64'(irq_pending[7]), 0);
        ticks(1);
        check("R8 equal", 64'(irq_pending[7]), 1);
        wr(B + 11, 8'h01);
        check("R8 raised cmp", 64'(irq_pending), 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_window();
        t_dir();
        t_pins();
        t_reserved();
        t_timer();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule